// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Address-Encoded Invalidation

This block is a small, fully associative translation lookaside buffer for locked and large-page translations. Each of its entries holds a virtual page number, a context number, a physical page number, a valid flag and a lock flag. A lookup compares the presented virtual page and context against every entry at once. It reports a hit and the physical page in the same cycle when exactly one valid entry matches.

Software maintains the buffer through three register-style ports. The first is a context port that holds a primary and a secondary context value; the nucleus context is fixed at zero. The second is a diagnostic port that writes or reads one whole entry, addressed by an entry index and an array identifier inside a byte address. The third is an invalidation (demap) port on which a single write carries its entire command in the address. Bit 7 asks for all unlocked entries to be removed. Bit 6 picks a context-wide demap over a single-page demap. Bits 5:4 name the context register to match, and the upper address bits carry the page.

Top module: `tlb_fa_demap`

## Requirements
- R1: After a synchronous active-low reset, every entry reads back with valid, lock and all fields zero, and both context registers read zero.
- R2: A context write with `ctx_wr_sel`=0 loads the primary register and with `ctx_wr_sel`=1 loads the secondary register; the new value is visible on `pri_ctx`/`sec_ctx` after the clock edge.
- R3: A diagnostic write loads valid, lock, context, virtual page and physical page of one entry in a single cycle. The entry index is `diag_addr[6:3]`, and the write applies only when the array field `diag_addr[17:16]` equals 0; any other array value leaves every entry unchanged.
- R4: A diagnostic read returns the five stored fields of the addressed entry with `diag_rd_ack` one cycle after `diag_rd_en`, and it changes no entry. A read aimed at a nonzero array field returns all fields zero.
- R5: A lookup reports `lk_hit`=1 and the matching entry's physical page in the same cycle when exactly one valid entry matches both `lk_vpn` and `lk_ctx`; with no match it reports a miss with `lk_ppn` zero.
- R6: When two or more valid entries match a lookup, the result is a miss with `lk_ppn` zero.
- R7: A demap with address bit 7 clear and bit 6 set invalidates every entry whose context equals the selected context, whatever its page and whatever its lock flag. Bits 5:4 select the context: 00 primary, 01 secondary, 10 nucleus (zero). So 0x40, 0x50 and 0x60 name the three contexts.
- R8: A demap with bits 7 and 6 clear invalidates only entries whose virtual page equals `dm_addr[31:13]` and whose context equals the one chosen by bits 5:4 (same coding as R7), whatever the lock flag.
- R9: A demap with bit 7 set (0x80) invalidates every entry whose lock flag is clear and leaves locked entries valid.
- R10: A page or context demap whose bits 5:4 equal 11 changes no entry.
- R11: A demap takes effect from the cycle after it is issued, so a lookup in the same cycle still sees the old contents. A diagnostic write to an entry in the same cycle as a demap that hits that entry leaves the written value in place.
- R12: A context demap issued in the same cycle as a write to the selected context register matches against the register's value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctx_wr_en | input | 1 | Context register write strobe |
| ctx_wr_sel | input | 1 | 0 selects primary, 1 selects secondary |
| ctx_wr_data | input | 13 | Context value to write |
| pri_ctx | output | 13 | Primary context register |
| sec_ctx | output | 13 | Secondary context register |
| dm_valid | input | 1 | Demap command strobe |
| dm_addr | input | 32 | Demap command encoded as an address |
| diag_addr | input | 32 | Diagnostic address: index in bits 6:3, array in bits 17:16 |
| diag_wr_en | input | 1 | Diagnostic entry write strobe |
| diag_wr_valid | input | 1 | Valid flag to write |
| diag_wr_lock | input | 1 | Lock flag to write |
| diag_wr_ctx | input | 13 | Context to write |
| diag_wr_vpn | input | 19 | Virtual page to write |
| diag_wr_ppn | input | 20 | Physical page to write |
| diag_rd_en | input | 1 | Diagnostic entry read strobe |
| diag_rd_ack | output | 1 | Read data valid, one cycle after the strobe |
| diag_rd_valid | output | 1 | Read valid flag |
| diag_rd_lock | output | 1 | Read lock flag |
| diag_rd_ctx | output | 13 | Read context |
| diag_rd_vpn | output | 19 | Read virtual page |
| diag_rd_ppn | output | 20 | Read physical page |
| lk_vpn | input | 19 | Lookup virtual page |
| lk_ctx | input | 13 | Lookup context |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Physical page on hit, zero otherwise |

## Verification
The table is filled with a pattern in which pairs of neighbouring entries share a page but differ in context, and every fourth entry is locked. A page demap must then pick out one member of a pair, a context demap must sweep across pages, and demap-all must separate locked from unlocked entries. After every command, all sixteen entries are read back and looked up and compared with a bench model. This exposes both over-invalidation and under-invalidation. Reserved selects, writes to another array, a duplicated entry, and same-cycle collisions of demap with lookup, diagnostic write and context write each test one ordering rule on its own.

// File: rtl/tlb_fa_pkg.sv
// Package: shared encodings for the fully associative translation buffer.
// Assumes the demap command bit positions below are fixed by software usage.
package tlb_fa_pkg;

    // Demap command bit positions inside the command address
    localparam int DM_ALL_BIT     = 7;
    localparam int DM_CTXMODE_BIT = 6;
    localparam int DM_SEL_LSB     = 4;

    // Diagnostic address: entry index starts at this bit
    localparam int DIAG_IDX_LSB   = 3;

    // Decoded demap operation
    typedef enum logic [1:0] {
        DM_NONE = 2'd0,
        DM_PAGE = 2'd1,
        DM_CTX  = 2'd2,
        DM_ALL  = 2'd3
    } dm_kind_e;

    // Context selector carried in the demap address
    typedef enum logic [1:0] {
        CSEL_PRI = 2'd0,
        CSEL_SEC = 2'd1,
        CSEL_NUC = 2'd2,
        CSEL_RSV = 2'd3
    } csel_e;

endpackage

// File: rtl/tlb_ctx_regs.sv
// Module: primary and secondary context registers.
// Assumes one write per cycle; the nucleus context is not stored here (it is zero).
module tlb_ctx_regs #(
    parameter int CTX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CTX_W-1:0] wr_data,
    output logic [CTX_W-1:0] pri_ctx,
    output logic [CTX_W-1:0] sec_ctx
);

    // Load the selected context register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_ctx <= '0;
            sec_ctx <= '0;
        end else if (wr_en) begin
            if (wr_sel) sec_ctx <= wr_data;
            else        pri_ctx <= wr_data;
        end
    end

endmodule

// File: rtl/tlb_demap_decode.sv
// Module: decodes a demap command address into an operation, a target
// context value and a target virtual page.
// Assumes PAGE_SHIFT > 8 so the page field does not overlap the command bits.
module tlb_demap_decode
    import tlb_fa_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int CTX_W      = 13,
    localparam int VPN_W     = ADDR_W - PAGE_SHIFT
) (
    input  logic              dm_valid,
    input  logic [ADDR_W-1:0] dm_addr,
    input  logic [CTX_W-1:0]  pri_ctx,
    input  logic [CTX_W-1:0]  sec_ctx,
    output dm_kind_e          dm_kind,
    output logic [CTX_W-1:0]  dm_ctx,
    output logic [VPN_W-1:0]  dm_vpn
);

    csel_e sel;
    logic  unused_bits;

    assign sel         = csel_e'(dm_addr[DM_SEL_LSB +: 2]);
    assign dm_vpn      = dm_addr[ADDR_W-1:PAGE_SHIFT];
    assign unused_bits = ^{dm_addr[PAGE_SHIFT-1:DM_ALL_BIT+1], dm_addr[DM_SEL_LSB-1:0]};

    // Pick the context value the command names
    always_comb begin
        case (sel)
            CSEL_PRI: dm_ctx = pri_ctx;
            CSEL_SEC: dm_ctx = sec_ctx;
            default:  dm_ctx = '0;
        endcase
    end

    // Classify the command; reserved selector voids page/context demaps
    always_comb begin
        if (!dm_valid)                    dm_kind = DM_NONE;
        else if (dm_addr[DM_ALL_BIT])     dm_kind = DM_ALL;
        else if (sel == CSEL_RSV)         dm_kind = DM_NONE;
        else if (dm_addr[DM_CTXMODE_BIT]) dm_kind = DM_CTX;
        else                              dm_kind = DM_PAGE;
    end

endmodule

// File: rtl/tlb_entry.sv
// Module: one translation entry with its own lookup comparator and demap match.
// Assumes a diagnostic write has priority over a demap in the same cycle.
module tlb_entry
    import tlb_fa_pkg::*;
#(
    parameter int VPN_W = 19,
    parameter int CTX_W = 13,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_valid,
    input  logic             wr_lock,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  dm_kind_e         dm_kind,
    input  logic [CTX_W-1:0] dm_ctx,
    input  logic [VPN_W-1:0] dm_vpn,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [CTX_W-1:0] lk_ctx,
    output logic             valid,
    output logic             lock,
    output logic [CTX_W-1:0] ctx,
    output logic [VPN_W-1:0] vpn,
    output logic [PPN_W-1:0] ppn,
    output logic             lk_match
);

    logic ctx_eq;
    logic dm_hit;

    assign ctx_eq = (ctx == dm_ctx);

    // Decide whether the current demap command removes this entry
    always_comb begin
        case (dm_kind)
            DM_ALL:  dm_hit = !lock;
            DM_CTX:  dm_hit = ctx_eq;
            DM_PAGE: dm_hit = ctx_eq && (vpn == dm_vpn);
            default: dm_hit = 1'b0;
        endcase
    end

    // Lookup comparator
    assign lk_match = valid && (vpn == lk_vpn) && (ctx == lk_ctx);

    // Entry storage: diagnostic write first, otherwise demap clears valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            lock  <= 1'b0;
            ctx   <= '0;
            vpn   <= '0;
            ppn   <= '0;
        end else if (wr_en) begin
            valid <= wr_valid;
            lock  <= wr_lock;
            ctx   <= wr_ctx;
            vpn   <= wr_vpn;
            ppn   <= wr_ppn;
        end else if (dm_hit) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/tlb_hit_select.sv
// Module: reduces per-entry match flags to a hit and a physical page.
// Assumes more than one match is a miss; output page is zero on a miss.
module tlb_hit_select #(
    parameter int NUM_ENTRIES = 16,
    parameter int PPN_W       = 20
) (
    input  logic [NUM_ENTRIES-1:0]            match,
    input  logic [NUM_ENTRIES-1:0][PPN_W-1:0] ppn_in,
    output logic                              hit,
    output logic [PPN_W-1:0]                  ppn
);

    logic [PPN_W-1:0] ppn_or;

    // OR together the pages of matching entries
    always_comb begin
        ppn_or = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match[i]) ppn_or = ppn_or | ppn_in[i];
        end
    end

    assign hit = ($countones(match) == 1);
    assign ppn = hit ? ppn_or : '0;

endmodule

// File: rtl/tlb_fa_demap.sv
// Module: fully associative translation buffer with diagnostic access and
// address-encoded demap commands.
// Assumes ARR_LSB lies above the entry index field and this array answers to ARRAY_ID.
module tlb_fa_demap
    import tlb_fa_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 13,
    parameter int CTX_W       = 13,
    parameter int PPN_W       = 20,
    parameter int ARR_LSB     = 16,
    parameter int ARR_W       = 2,
    parameter int ARRAY_ID    = 0,
    localparam int VPN_W      = ADDR_W - PAGE_SHIFT,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctx_wr_en,
    input  logic              ctx_wr_sel,
    input  logic [CTX_W-1:0]  ctx_wr_data,
    output logic [CTX_W-1:0]  pri_ctx,
    output logic [CTX_W-1:0]  sec_ctx,
    input  logic              dm_valid,
    input  logic [ADDR_W-1:0] dm_addr,
    input  logic [ADDR_W-1:0] diag_addr,
    input  logic              diag_wr_en,
    input  logic              diag_wr_valid,
    input  logic              diag_wr_lock,
    input  logic [CTX_W-1:0]  diag_wr_ctx,
    input  logic [VPN_W-1:0]  diag_wr_vpn,
    input  logic [PPN_W-1:0]  diag_wr_ppn,
    input  logic              diag_rd_en,
    output logic              diag_rd_ack,
    output logic              diag_rd_valid,
    output logic              diag_rd_lock,
    output logic [CTX_W-1:0]  diag_rd_ctx,
    output logic [VPN_W-1:0]  diag_rd_vpn,
    output logic [PPN_W-1:0]  diag_rd_ppn,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [CTX_W-1:0]  lk_ctx,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn
);

    dm_kind_e         dm_kind;
    logic [CTX_W-1:0] dm_ctx;
    logic [VPN_W-1:0] dm_vpn;

    logic [NUM_ENTRIES-1:0]            ent_valid;
    logic [NUM_ENTRIES-1:0]            ent_lock;
    logic [NUM_ENTRIES-1:0]            lk_match;
    logic [NUM_ENTRIES-1:0][CTX_W-1:0] ent_ctx;
    logic [NUM_ENTRIES-1:0][VPN_W-1:0] ent_vpn;
    logic [NUM_ENTRIES-1:0][PPN_W-1:0] ent_ppn;

    logic [IDX_W-1:0] diag_idx;
    logic             diag_arr_ok;
    logic             unused_diag;

    assign diag_idx    = diag_addr[DIAG_IDX_LSB +: IDX_W];
    assign diag_arr_ok = (diag_addr[ARR_LSB +: ARR_W] == ARR_W'(ARRAY_ID));
    assign unused_diag = ^{diag_addr[ADDR_W-1:ARR_LSB+ARR_W],
                           diag_addr[ARR_LSB-1:DIAG_IDX_LSB+IDX_W],
                           diag_addr[DIAG_IDX_LSB-1:0]};

    tlb_ctx_regs #(.CTX_W(CTX_W)) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctx_wr_en),
        .wr_sel  (ctx_wr_sel),
        .wr_data (ctx_wr_data),
        .pri_ctx (pri_ctx),
        .sec_ctx (sec_ctx)
    );

    tlb_demap_decode #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .CTX_W      (CTX_W)
    ) u_dec (
        .dm_valid (dm_valid),
        .dm_addr  (dm_addr),
        .pri_ctx  (pri_ctx),
        .sec_ctx  (sec_ctx),
        .dm_kind  (dm_kind),
        .dm_ctx   (dm_ctx),
        .dm_vpn   (dm_vpn)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        tlb_entry #(
            .VPN_W (VPN_W),
            .CTX_W (CTX_W),
            .PPN_W (PPN_W)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (diag_wr_en && diag_arr_ok && (diag_idx == IDX_W'(i))),
            .wr_valid (diag_wr_valid),
            .wr_lock  (diag_wr_lock),
            .wr_ctx   (diag_wr_ctx),
            .wr_vpn   (diag_wr_vpn),
            .wr_ppn   (diag_wr_ppn),
            .dm_kind  (dm_kind),
            .dm_ctx   (dm_ctx),
            .dm_vpn   (dm_vpn),
            .lk_vpn   (lk_vpn),
            .lk_ctx   (lk_ctx),
            .valid    (ent_valid[i]),
            .lock     (ent_lock[i]),
            .ctx      (ent_ctx[i]),
            .vpn      (ent_vpn[i]),
            .ppn      (ent_ppn[i]),
            .lk_match (lk_match[i])
        );
    end

    tlb_hit_select #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .PPN_W       (PPN_W)
    ) u_sel (
        .match  (lk_match),
        .ppn_in (ent_ppn),
        .hit    (lk_hit),
        .ppn    (lk_ppn)
    );

    // Registered diagnostic read; foreign array returns zeros
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diag_rd_ack   <= 1'b0;
            diag_rd_valid <= 1'b0;
            diag_rd_lock  <= 1'b0;
            diag_rd_ctx   <= '0;
            diag_rd_vpn   <= '0;
            diag_rd_ppn   <= '0;
        end else begin
            diag_rd_ack <= diag_rd_en;
            if (diag_rd_en) begin
                if (diag_arr_ok) begin
                    diag_rd_valid <= ent_valid[diag_idx];
                    diag_rd_lock  <= ent_lock[diag_idx];
                    diag_rd_ctx   <= ent_ctx[diag_idx];
                    diag_rd_vpn   <= ent_vpn[diag_idx];
                    diag_rd_ppn   <= ent_ppn[diag_idx];
                end else begin
                    diag_rd_valid <= 1'b0;
                    diag_rd_lock  <= 1'b0;
                    diag_rd_ctx   <= '0;
                    diag_rd_vpn   <= '0;
                    diag_rd_ppn   <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/tlb_fa_demap_chk.sv
// Module: property checker for tlb_fa_demap, bound into every instance.
// Assumes it sees the per-entry valid/lock flags and lookup match flags.
module tlb_fa_demap_chk #(
    parameter int NUM_ENTRIES = 16,
    parameter int CTX_W       = 13
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   dm_valid,
    input logic                   dm_all,
    input logic                   ctx_wr_en,
    input logic                   ctx_wr_sel,
    input logic [CTX_W-1:0]       ctx_wr_data,
    input logic [CTX_W-1:0]       pri_ctx,
    input logic [CTX_W-1:0]       sec_ctx,
    input logic                   diag_wr_en,
    input logic                   diag_rd_en,
    input logic                   lk_hit,
    input logic [NUM_ENTRIES-1:0] ent_valid,
    input logic [NUM_ENTRIES-1:0] ent_lock,
    input logic [NUM_ENTRIES-1:0] lk_match
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ent_valid == '0));

    assert_pri_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_wr_en && !ctx_wr_sel) |=> (pri_ctx == $past(ctx_wr_data)));

    assert_sec_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_wr_en && ctx_wr_sel) |=> (sec_ctx == $past(ctx_wr_data)));

    assert_read_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_rd_en && !diag_wr_en && !dm_valid) |=> (ent_valid == $past(ent_valid)));

    assert_hit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ($countones(lk_match) == 1));

    assert_multi_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lk_match) > 1) |-> !lk_hit);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chk
        assert_all_spares_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (dm_all && !diag_wr_en && ent_lock[i] && ent_valid[i]) |=> ent_valid[i]);

        assert_all_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (dm_all && !diag_wr_en && !ent_lock[i]) |=> !ent_valid[i]);
    end

endmodule

bind tlb_fa_demap tlb_fa_demap_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .CTX_W       (CTX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dm_valid    (dm_valid),
    .dm_all      (dm_valid && dm_addr[7]),
    .ctx_wr_en   (ctx_wr_en),
    .ctx_wr_sel  (ctx_wr_sel),
    .ctx_wr_data (ctx_wr_data),
    .pri_ctx     (pri_ctx),
    .sec_ctx     (sec_ctx),
    .diag_wr_en  (diag_wr_en),
    .diag_rd_en  (diag_rd_en),
    .lk_hit      (lk_hit),
    .ent_valid   (ent_valid),
    .ent_lock    (ent_lock),
    .lk_match    (lk_match)
);

// File: tb/tlb_fa_demap_tb.sv
// Bench: sweeps every entry after each command against a bench-side model.
module tlb_fa_demap_tb;

    localparam int N     = 16;
    localparam int CTX_W = 13;
    localparam int VPN_W = 19;
    localparam int PPN_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctx_wr_en = 1'b0;
    logic             ctx_wr_sel = 1'b0;
    logic [CTX_W-1:0] ctx_wr_data = '0;
    logic [CTX_W-1:0] pri_ctx, sec_ctx;
    logic             dm_valid = 1'b0;
    logic [31:0]      dm_addr = '0;
    logic [31:0]      diag_addr = '0;
    logic             diag_wr_en = 1'b0;
    logic             diag_wr_valid = 1'b0;
    logic             diag_wr_lock = 1'b0;
    logic [CTX_W-1:0] diag_wr_ctx = '0;
    logic [VPN_W-1:0] diag_wr_vpn = '0;
    logic [PPN_W-1:0] diag_wr_ppn = '0;
    logic             diag_rd_en = 1'b0;
    logic             diag_rd_ack, diag_rd_valid, diag_rd_lock;
    logic [CTX_W-1:0] diag_rd_ctx;
    logic [VPN_W-1:0] diag_rd_vpn;
    logic [PPN_W-1:0] diag_rd_ppn;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [CTX_W-1:0] lk_ctx = '0;
    logic             lk_hit;
    logic [PPN_W-1:0] lk_ppn;

    int n_chk = 0;
    int n_err = 0;

    // model state
    logic             mv [N];
    logic             ml [N];
    logic [CTX_W-1:0] mc [N];
    logic [VPN_W-1:0] mvpn [N];
    logic [PPN_W-1:0] mppn [N];
    logic [CTX_W-1:0] mpri = '0;
    logic [CTX_W-1:0] msec = '0;

    always #5 clk = ~clk;

    tlb_fa_demap u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctx_wr_en(ctx_wr_en), .ctx_wr_sel(ctx_wr_sel), .ctx_wr_data(ctx_wr_data),
        .pri_ctx(pri_ctx), .sec_ctx(sec_ctx),
        .dm_valid(dm_valid), .dm_addr(dm_addr),
        .diag_addr(diag_addr), .diag_wr_en(diag_wr_en),
        .diag_wr_valid(diag_wr_valid), .diag_wr_lock(diag_wr_lock),
        .diag_wr_ctx(diag_wr_ctx), .diag_wr_vpn(diag_wr_vpn), .diag_wr_ppn(diag_wr_ppn),
        .diag_rd_en(diag_rd_en), .diag_rd_ack(diag_rd_ack),
        .diag_rd_valid(diag_rd_valid), .diag_rd_lock(diag_rd_lock),
        .diag_rd_ctx(diag_rd_ctx), .diag_rd_vpn(diag_rd_vpn), .diag_rd_ppn(diag_rd_ppn),
        .lk_vpn(lk_vpn), .lk_ctx(lk_ctx), .lk_hit(lk_hit), .lk_ppn(lk_ppn)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] diag_a(int arr, int idx);
        return (32'(arr) << 16) | (32'(idx) << 3);
    endfunction

    function automatic logic [CTX_W-1:0] pat_ctx(int i);
        if (i % 3 == 0) return '0;
        else if (i % 3 == 1) return mpri;
        else return msec;
    endfunction

    // demap effect on the model from the R7-R10 encoding
    task automatic model_demap(logic [31:0] a);
        logic [CTX_W-1:0] tc;
        if (a[7]) begin
            for (int i = 0; i < N; i++) if (!ml[i]) mv[i] = 1'b0;
        end else if (a[5:4] != 2'b11) begin
            tc = (a[5:4] == 2'b00) ? mpri : (a[5:4] == 2'b01) ? msec : '0;
            for (int i = 0; i < N; i++)
                if (mc[i] == tc && (a[6] || mvpn[i] == a[31:13])) mv[i] = 1'b0;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ctx_write(logic sel, logic [CTX_W-1:0] d);
        ctx_wr_en = 1'b1; ctx_wr_sel = sel; ctx_wr_data = d;
        tick();
        ctx_wr_en = 1'b0;
        if (sel) msec = d; else mpri = d;
    endtask

    task automatic set_diag_wr(int arr, int idx, logic v, logic l, logic [CTX_W-1:0] c,
                               logic [VPN_W-1:0] vp, logic [PPN_W-1:0] pp);
        diag_addr = diag_a(arr, idx);
        diag_wr_en = 1'b1; diag_wr_valid = v; diag_wr_lock = l;
        diag_wr_ctx = c; diag_wr_vpn = vp; diag_wr_ppn = pp;
    endtask

    task automatic model_write(int arr, int idx, logic v, logic l, logic [CTX_W-1:0] c,
                               logic [VPN_W-1:0] vp, logic [PPN_W-1:0] pp);
        if (arr == 0) begin
            mv[idx] = v; ml[idx] = l; mc[idx] = c; mvpn[idx] = vp; mppn[idx] = pp;
        end
    endtask

    task automatic diag_write(int arr, int idx, logic v, logic l, logic [CTX_W-1:0] c,
                              logic [VPN_W-1:0] vp, logic [PPN_W-1:0] pp);
        set_diag_wr(arr, idx, v, l, c, vp, pp);
        tick();
        diag_wr_en = 1'b0;
        model_write(arr, idx, v, l, c, vp, pp);
    endtask

    task automatic demap(logic [31:0] a);
        dm_valid = 1'b1; dm_addr = a;
        tick();
        dm_valid = 1'b0;
        model_demap(a);
    endtask

    task automatic diag_read(int arr, int idx);
        diag_addr = diag_a(arr, idx);
        diag_rd_en = 1'b1;
        tick();
        diag_rd_en = 1'b0;
    endtask

    task automatic fill_all();
        for (int i = 0; i < N; i++)
            diag_write(0, i, 1'b1, (i % 4 == 0), pat_ctx(i),
                       VPN_W'(32'h40 + i / 2), PPN_W'(32'h100 + i * 7));
    endtask

    // expected lookup result from the model (R5, R6)
    task automatic expect_lookup(logic [VPN_W-1:0] vp, logic [CTX_W-1:0] c,
                                 output logic h, output logic [PPN_W-1:0] p);
        int cnt = 0;
        p = '0;
        for (int i = 0; i < N; i++)
            if (mv[i] && mvpn[i] == vp && mc[i] == c) begin cnt++; p = mppn[i]; end
        h = (cnt == 1);
        if (!h) p = '0;
    endtask

    task automatic lookup_check(string req, logic [VPN_W-1:0] vp, logic [CTX_W-1:0] c);
        logic eh;
        logic [PPN_W-1:0] ep;
        lk_vpn = vp; lk_ctx = c;
        #1;
        expect_lookup(vp, c, eh, ep);
        check(req, "lookup hit", 64'(lk_hit), 64'(eh));
        check(req, "lookup ppn", 64'(lk_ppn), 64'(ep));
    endtask

    // read back and look up every entry against the model
    task automatic sweep(string req);
        for (int i = 0; i < N; i++) begin
            diag_read(0, i);
            check(req, "rd ack", 64'(diag_rd_ack), 64'd1);
            check(req, $sformatf("e%0d valid", i), 64'(diag_rd_valid), 64'(mv[i]));
            check(req, $sformatf("e%0d lock", i), 64'(diag_rd_lock), 64'(ml[i]));
            check(req, $sformatf("e%0d ctx", i), 64'(diag_rd_ctx), 64'(mc[i]));
            check(req, $sformatf("e%0d vpn", i), 64'(diag_rd_vpn), 64'(mvpn[i]));
            check(req, $sformatf("e%0d ppn", i), 64'(diag_rd_ppn), 64'(mppn[i]));
        end
        for (int i = 0; i < N; i++) lookup_check(req, mvpn[i], mc[i]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < N; i++) begin
            mv[i] = 1'b0; ml[i] = 1'b0; mc[i] = '0; mvpn[i] = '0; mppn[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state
        check("R1", "pri_ctx", 64'(pri_ctx), 64'd0);
        check("R1", "sec_ctx", 64'(sec_ctx), 64'd0);
        sweep("R1");

        // R2: context registers
        ctx_write(1'b0, 13'h123);
        check("R2", "pri_ctx", 64'(pri_ctx), 64'h123);
        check("R2", "sec_ctx untouched", 64'(sec_ctx), 64'd0);
        ctx_write(1'b1, 13'h456);
        check("R2", "sec_ctx", 64'(sec_ctx), 64'h456);
        check("R2", "pri_ctx kept", 64'(pri_ctx), 64'h123);

        // R3/R4/R5: fill and verify
        fill_all();
        sweep("R3");

        // R3: write to a foreign array is ignored
        diag_write(1, 0, 1'b1, 1'b0, 13'h1fff, 19'h7ffff, 20'hfffff);
        sweep("R3");

        // R4: foreign array read returns zeros
        diag_read(2, 3);
        check("R4", "foreign valid", 64'(diag_rd_valid), 64'd0);
        check("R4", "foreign ppn", 64'(diag_rd_ppn), 64'd0);
        check("R4", "foreign vpn", 64'(diag_rd_vpn), 64'd0);

        // R5: miss on wrong context and on absent page
        lookup_check("R5", 19'h40, 13'h456);
        lookup_check("R5", 19'h7ff, 13'h0);

        // R6: duplicate entry makes a miss
        diag_write(0, 15, 1'b1, 1'b0, mc[14], mvpn[14], 20'h0abcd);
        lookup_check("R6", mvpn[14], mc[14]);
        check("R6", "dup miss", 64'(lk_hit), 64'd0);
        diag_write(0, 15, 1'b1, 1'b0, 13'h0, 19'h55, 20'h0777);
        sweep("R6");

        // R11: lookup in the demap cycle sees old contents
        lk_vpn = mvpn[1]; lk_ctx = mc[1];
        dm_valid = 1'b1; dm_addr = 32'h40;
        #1;
        check("R11", "hit during demap cycle", 64'(lk_hit), 64'd1);
        tick();
        dm_valid = 1'b0;
        model_demap(32'h40);
        check("R11", "miss after demap", 64'(lk_hit), 64'd0);
        sweep("R7");

        // R8: page demaps, including a locked nucleus entry
        fill_all();
        demap({13'h0, 19'h40} << 13 | 32'h00);
        sweep("R8");
        demap((32'h40 << 13) | 32'h20);
        check("R8", "locked entry 0 removed", 64'(mv[0]), 64'd0);
        sweep("R8");
        demap((32'h41 << 13) | 32'h10);
        sweep("R8");

        // R7: secondary context demap removes locked entry 8 too
        fill_all();
        demap(32'h50);
        sweep("R7");

        // R10: reserved selector is ignored
        demap(32'h70);
        demap((32'h43 << 13) | 32'h30);
        sweep("R10");

        // R9: demap all spares locked entries
        fill_all();
        demap(32'h80);
        sweep("R9");

        // R7: nucleus context demap
        fill_all();
        demap(32'h60);
        sweep("R7");

        // R11: diagnostic write beats demap on the same entry
        fill_all();
        set_diag_wr(0, 4, 1'b1, 1'b0, mpri, 19'h66, 20'h0c0de);
        dm_valid = 1'b1; dm_addr = 32'h40;
        tick();
        dm_valid = 1'b0; diag_wr_en = 1'b0;
        model_demap(32'h40);
        model_write(0, 4, 1'b1, 1'b0, mpri, 19'h66, 20'h0c0de);
        sweep("R11");

        // R12: demap uses context value from before a same-cycle write
        fill_all();
        ctx_wr_en = 1'b1; ctx_wr_sel = 1'b0; ctx_wr_data = 13'h777;
        dm_valid = 1'b1; dm_addr = 32'h40;
        tick();
        ctx_wr_en = 1'b0; dm_valid = 1'b0;
        model_demap(32'h40);
        mpri = 13'h777;
        check("R12", "pri_ctx new", 64'(pri_ctx), 64'h777);
        sweep("R12");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule